// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational 20-bit unsigned adder. It takes two operands and a carry-in and returns a 20-bit sum and a carry-out. The operand width is cut into five blocks, and each block is one bit wider than the block below it.

Every block forms per-bit generate and propagate terms from its own operand bits. It then ripples two carry chains side by side. One chain assumes the incoming carry is 0 and the other assumes it is 1. When the real carry reaches a block, a 2:1 selector picks that block's carry vector and carry-out. The selected carry-out then drives the selector of the next block up.

Sum bits are formed after selection, as each bit's propagate XOR the selected carry into that bit. The wider blocks at the top have more time to finish their chains while the selector chain climbs through the narrow blocks below. This keeps the two paths balanced. The block has no clock and no reset, and it is placed between registers owned by the surrounding datapath.

Top module: `csel_adder`

## Requirements
- R1: For every input pattern, the 21-bit value {cout_o, sum_o} equals a_i + b_i + cin_i.
- R2: The blocks, from the least significant end, hold 2, 3, 4, 5 and 6 bits, covering bit ranges 0-1, 2-4, 5-8, 9-13 and 14-19. A carry that enters a block whose bits all propagate leaves at the block's top and lands on the next block's lowest bit.
- R3: A generate at the top bit of any block (a and b both 1 at bits 1, 4, 8, 13) puts a 1 on the next block's lowest sum bit. A generate at bit 19 puts a 1 on cout_o.
- R4: Each block computes a carry chain for an assumed incoming carry of 0 and a second chain for an assumed carry of 1. At no bit is the 0-assumption carry set while the 1-assumption carry is clear. When some bit in the block kills or generates, both chains give the same carry-out.
- R5: When every bit position propagates, the carry-in passes through all five selectors. All-ones plus zero with carry-in 1 gives sum 0 and carry-out 1. The same operands with carry-in 0 give all-ones and carry-out 0.
- R6: The carry-in alone drives the lowest block's selector, so zero plus zero with carry-in 1 gives sum 1 and carry-out 0.
- R7: cout_o equals the selected carry-out of the 6-bit block (bits 14-19). For example, 0x80000 + 0x80000 gives sum 0 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 20 | First unsigned operand |
| b_i | input | 20 | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum bits |
| cout_o | output | 1 | Carry out of bit 19 |

## Verification
The assertions inside each block are evaluated whenever its operands change. They check the relation between the two precomputed carry chains: the chains never invert their order, they agree on the carry-out unless the whole block propagates, they split cleanly when it does, and a top-bit generate forces both carry-outs high. Whether the selectors are wired to the right block boundaries, and whether the final sum is arithmetically correct, can only be shown by the bench's scenarios. These include a full sweep of every operand pair inside each block with a controlled incoming carry, the boundary generate and propagate cases, full propagation from carry-in to carry-out, and random operands compared against integer addition.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Lowest bit index of block idx when block widths grow by one per block
  function automatic int blk_lsb(input int first_w, input int idx);
    return idx * first_w + (idx * (idx - 1)) / 2;
  endfunction

  // Width of block idx
  function automatic int blk_width(input int first_w, input int idx);
    return first_w + idx;
  endfunction

  // Total operand width covered by nblk blocks
  function automatic int total_width(input int first_w, input int nblk);
    return blk_lsb(first_w, nblk);
  endfunction

endpackage

// File: rtl/csel_block.sv
// Setup and dual-hypothesis carry chains for one select block
module csel_block #(
  parameter int BW = 2
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [BW-1:0] prop_o,
  output logic [BW:0]   cz_o,
  output logic [BW:0]   co_o
);

  logic [BW-1:0] gen;
  logic [BW-1:0] prop;
  logic [BW:0]   cz;
  logic [BW:0]   co;

  always_comb begin
    gen   = a_i & b_i;
    prop  = a_i ^ b_i;
    cz    = '0;
    co    = '0;
    cz[0] = 1'b0;
    co[0] = 1'b1;
    for (int k = 0; k < BW; k++) begin
      cz[k+1] = gen[k] | (prop[k] & cz[k]);
      co[k+1] = gen[k] | (prop[k] & co[k]);
    end

    AST_CHAIN_MONOTONIC: assert ((cz & ~co) == '0)
      else $error("zero-assumed carry above one-assumed carry"); // R4
    AST_KILL_AGREE: assert ((&prop) || (cz[BW] == co[BW]))
      else $error("carry-outs differ without full propagate"); // R4
    AST_FULL_PROP: assert (!(&prop) || (!cz[BW] && co[BW]))
      else $error("full propagate did not pass hypothesis"); // R5
    AST_GEN_TOP: assert (!gen[BW-1] || (cz[BW] && co[BW]))
      else $error("top generate lost"); // R3
  end

  assign prop_o = prop;
  assign cz_o   = cz;
  assign co_o   = co;

endmodule

// File: rtl/csel_sel.sv
// Carry selector and sum generation for one block
module csel_sel #(
  parameter int BW = 2
) (
  input  logic [BW-1:0] prop_i,
  input  logic [BW:0]   cz_i,
  input  logic [BW:0]   co_i,
  input  logic          cin_i,
  output logic [BW-1:0] sum_o,
  output logic          cout_o
);

  logic [BW:0] carries;

  assign carries = cin_i ? co_i : cz_i;
  assign sum_o   = prop_i ^ carries[BW-1:0];
  assign cout_o  = carries[BW];

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int FIRST_W = 2,
  parameter int NBLK    = 5,
  localparam int W      = csel_pkg::total_width(FIRST_W, NBLK)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  // Selected carry entering each block; the last entry leaves the adder
  logic [NBLK:0] blk_c;

  assign blk_c[0] = cin_i;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam int LSB = csel_pkg::blk_lsb(FIRST_W, i);
    localparam int BW  = csel_pkg::blk_width(FIRST_W, i);

    logic [BW-1:0] prop;
    logic [BW:0]   cz;
    logic [BW:0]   co;

    csel_block #(.BW(BW)) u_blk (
      .a_i    (a_i[LSB +: BW]),
      .b_i    (b_i[LSB +: BW]),
      .prop_o (prop),
      .cz_o   (cz),
      .co_o   (co)
    );

    csel_sel #(.BW(BW)) u_sel (
      .prop_i (prop),
      .cz_i   (cz),
      .co_i   (co),
      .cin_i  (blk_c[i]),
      .sum_o  (sum_o[LSB +: BW]),
      .cout_o (blk_c[i+1])
    );
  end

  assign cout_o = blk_c[NBLK];

endmodule

// File: tb/sim_csel_adder.sv
`timescale 1ns/1ps
module sim_csel_adder;

  localparam int W = 20;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           checks = 0;
  int           errors = 0;

  always #10 clk = ~clk;

  csel_adder u0 (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic c, input string tag);
    logic [W:0] expv;
    @(posedge clk);
    a   = av;
    b   = bv;
    cin = c;
    @(negedge clk);
    expv = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, c};
    checks++;
    if ({cout, sum} !== expv) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h expected=%h",
               tag, av, bv, c, {cout, sum}, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lsb [5] = '{0, 2, 5, 9, 14};
    int wid [5] = '{2, 3, 4, 5, 6};
    a = '0; b = '0; cin = 1'b0;

    // R1: quiescent inputs
    apply('0, '0, 1'b0, "R1 zero");
    // R6: carry-in alone
    apply('0, '0, 1'b1, "R6 carry-in only");
    // R5: full propagation across all blocks
    apply('1, '0, 1'b1, "R5 all-ones plus cin");
    apply('1, '0, 1'b0, "R5 all-ones no cin");
    apply('0, '1, 1'b1, "R5 swapped all-ones plus cin");
    // R7: top block generate
    apply(20'h80000, 20'h80000, 1'b0, "R7 top generate");
    apply(20'hFC000, 20'h04000, 1'b0, "R7 top block propagate");

    for (int i = 0; i < 5; i++) begin
      int top = lsb[i] + wid[i] - 1;
      logic [W-1:0] bmask = ((W'(1) << wid[i]) - W'(1)) << lsb[i];
      // R3: generate at top bit of block
      apply(W'(1) << top, W'(1) << top, 1'b0, "R3 boundary generate");
      // R2: carry entering a fully propagating block crosses it
      apply(bmask, W'(1) << lsb[i], 1'b0, "R2 block crossing");
      if (i > 0)
        apply(bmask, W'(1) << (lsb[i] - 1), 1'b0, "R2 carry from below");
    end

    // R4: full sweep inside each block with a controlled incoming carry
    for (int i = 0; i < 5; i++) begin
      for (int av = 0; av < (1 << wid[i]); av++) begin
        for (int bv = 0; bv < (1 << wid[i]); bv++) begin
          for (int c = 0; c < 2; c++) begin
            logic [W-1:0] low = (W'(1) << lsb[i]) - W'(1);
            logic [W-1:0] up  = W'($urandom) & ~(((W'(1) << (lsb[i] + wid[i])) - W'(1)));
            logic [W-1:0] ax  = up | (W'(av) << lsb[i]) | (c[0] ? low : '0);
            logic [W-1:0] bx  = (W'(bv) << lsb[i]);
            apply(ax, bx, c[0], "R4 block sweep");
          end
        end
      end
    end

    // R1: random operands
    for (int n = 0; n < 4000; n++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 random");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule